// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the point where instructions become ready and the execution units. Each ready instruction is written in with a sequence number, an operation class and a short payload tag, and is kept in a small queue for its class. Each class queue feeds one kind of functional unit. In every cycle the block issues up to a fixed number of instructions. It takes them from the heads of the class queues and always prefers the globally oldest head, as long as that class's unit reports it can accept work.

A rank register keeps one age position for each non-empty class queue, ordered by that queue's oldest entry. The positions are recomputed from the next-cycle queue heads whenever a head leaves, a queue gains its first entry, or a squash trims a queue. Selection therefore only compares small rank values. A squash removes every entry younger than a given sequence number, using a wrap-aware comparison. A running counter records how often a non-empty class was held back by a busy unit.

Top module: `age_issue_sel`

## Requirements
- R1: While reset is high and in the first cycle after it, every issue slot is invalid, the busy-stall counter reads 0 and no class reports full.
- R2: An insertion presented in cycle N (ins_valid high, target class not full, no squash) can appear on an issue slot at the earliest after the second rising edge, and carries the same tag that was inserted.
- R3: A class reports full when it holds DEPTH entries. An insertion into a full class is dropped and never issues.
- R4: Each cycle, the block looks at the heads of the non-empty classes whose unit-free bit is 1. It issues up to ISSUE_W of them, oldest sequence first, with at most one per class. Slot 0 holds the oldest, and slots fill from 0 upward with no gaps.
- R5: Within one class, entries issue in insertion order. Insertions must arrive in ascending sequence order.
- R6: A class whose unit-free bit is 0 issues nothing that cycle. Younger heads of other classes with free units take the slots instead.
- R7: In every cycle without a squash, the stall counter (wrapping, STALL_W bits) increases by the number of non-empty classes whose unit-free bit is 0.
- R8: A squash removes every entry whose sequence number is younger than the squash point. In that cycle nothing issues, no insertion is accepted and the stall counter holds.
- R9: Sequence age is taken from the SEQ_W-bit difference: a is younger than b when (a-b) mod 2^SEQ_W lies in 1 .. 2^(SEQ_W-1)-1. For example, 3 is younger than 250 at 8 bits.
- R10: The issue outputs are registered. Each valid slot stands for exactly one cycle per issued entry, and iss_class gives the class index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert one ready instruction |
| ins_seq | input | SEQ_W | Sequence number of the inserted entry |
| ins_class | input | $clog2(NUM_CLS) | Operation class of the inserted entry |
| ins_tag | input | TAG_W | Payload tag of the inserted entry |
| fu_free | input | NUM_CLS | Per-class unit can accept an instruction |
| squash_valid | input | 1 | Remove entries younger than squash_seq |
| squash_seq | input | SEQ_W | Squash point |
| iss_valid | output | ISSUE_W | Per-slot issue valid, slot 0 oldest |
| iss_seq | output | ISSUE_W*SEQ_W | Issued sequence numbers, slot k at bits k*SEQ_W |
| iss_class | output | ISSUE_W*$clog2(NUM_CLS) | Issued class indices |
| iss_tag | output | ISSUE_W*TAG_W | Issued tags |
| cls_full | output | NUM_CLS | Per-class queue full |
| stall_cnt | output | STALL_W | Busy-unit stall counter |

## Verification
The bench builds the block with four classes, eight entries per class, an issue width of two and 8-bit sequence numbers. With these values a class can be filled to overflow with a few inserts. With two slots shared among four classes, the oldest-first choice and the one-per-class limit are both tested. The short sequence field means the random phase wraps sequence numbers many times, so the wrap-aware age compare and the squash trimming are exercised across the 255-to-0 boundary.

// File: rtl/age_issue_pkg.sv
`timescale 1ns/1ps
package age_issue_pkg;
  // a is younger than b when (a-b) modulo 2^w is nonzero and below half range
  function automatic logic is_younger(input logic [31:0] a, input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] msk;
    logic [31:0] dif;
    msk = (32'd1 << w) - 32'd1;
    dif = (a - b) & msk;
    return (dif != 32'd0) && (((dif >> (w - 1)) & 32'd1) == 32'd0);
  endfunction
endpackage

// File: rtl/age_cls_fifo.sv
`timescale 1ns/1ps
module age_cls_fifo #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop_en,
  input  logic             sq_en,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [SEQ_W-1:0] head_seq,
  output logic [TAG_W-1:0] head_tag,
  output logic             nonempty,
  output logic             full,
  output logic [SEQ_W-1:0] nxt_head_seq,
  output logic             nxt_nonempty
);
  import age_issue_pkg::*;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PW-1:0]    rd_q, wr_q, rd_n, wr_n;
  logic [CW-1:0]    cnt_q, cnt_n, keep_cnt;
  logic             do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign head_seq = seq_q[rd_q];
  assign head_tag = tag_q[rd_q];
  assign do_push  = push_en & ~full & ~sq_en;
  assign do_pop   = pop_en & nonempty & ~sq_en;

  // entries are stored oldest first, so survivors of a squash form a prefix
  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt_q &&
          !is_younger(32'(seq_q[rd_q + PW'(i)]), 32'(sq_seq), SEQ_W))
        keep_cnt = keep_cnt + CW'(1);
    end
  end

  always_comb begin
    if (sq_en) begin
      rd_n  = rd_q;
      wr_n  = rd_q + PW'(keep_cnt);
      cnt_n = keep_cnt;
    end else begin
      rd_n  = rd_q + PW'(do_pop);
      wr_n  = wr_q + PW'(do_push);
      cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
    end
    nxt_nonempty = (cnt_n != '0);
    if (do_push && (cnt_q - CW'(do_pop)) == '0) nxt_head_seq = push_seq;
    else                                         nxt_head_seq = seq_q[rd_n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      seq_q[wr_q] <= push_seq;
      tag_q[wr_q] <= push_tag;
    end
  end
endmodule

// File: rtl/age_rank.sv
`timescale 1ns/1ps
module age_rank #(
  parameter int NUM_CLS = 4,
  parameter int SEQ_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SEQ_W-1:0]           nxt_head [NUM_CLS],
  input  logic [NUM_CLS-1:0]         nxt_ne,
  output logic [$clog2(NUM_CLS)-1:0] rank [NUM_CLS],
  output logic [NUM_CLS-1:0]         on_list
);
  import age_issue_pkg::*;
  localparam int RW = $clog2(NUM_CLS);

  logic [RW-1:0] rank_n [NUM_CLS];

  // position of each queue head among the non-empty queues of the next cycle
  always_comb begin
    for (int c = 0; c < NUM_CLS; c++) begin
      rank_n[c] = '0;
      for (int d = 0; d < NUM_CLS; d++) begin
        if (d != c && nxt_ne[d] &&
            (is_younger(32'(nxt_head[c]), 32'(nxt_head[d]), SEQ_W) ||
             (nxt_head[c] == nxt_head[d] && d < c)))
          rank_n[c] = rank_n[c] + RW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_list <= '0;
      for (int c = 0; c < NUM_CLS; c++) rank[c] <= '0;
    end else begin
      on_list <= nxt_ne;
      for (int c = 0; c < NUM_CLS; c++) rank[c] <= rank_n[c];
    end
  end
endmodule

// File: rtl/age_pick.sv
`timescale 1ns/1ps
module age_pick #(
  parameter int NUM_CLS = 4,
  parameter int ISSUE_W = 2
) (
  input  logic [$clog2(NUM_CLS)-1:0] rank [NUM_CLS],
  input  logic [NUM_CLS-1:0]         on_list,
  input  logic [NUM_CLS-1:0]         fu_free,
  input  logic                       sq_en,
  output logic [ISSUE_W-1:0]         pick_vld,
  output logic [$clog2(NUM_CLS)-1:0] pick_cls [ISSUE_W],
  output logic [NUM_CLS-1:0]         pop
);
  localparam int CLW = $clog2(NUM_CLS);
  localparam int EW  = $clog2(NUM_CLS + 1);

  logic [NUM_CLS-1:0] elig;
  logic [EW-1:0]      epos [NUM_CLS];

  assign elig = on_list & fu_free & {NUM_CLS{~sq_en}};

  always_comb begin
    for (int c = 0; c < NUM_CLS; c++) begin
      epos[c] = '0;
      for (int d = 0; d < NUM_CLS; d++)
        if (elig[d] && rank[d] < rank[c]) epos[c] = epos[c] + EW'(1);
      pop[c] = elig[c] && (epos[c] < EW'(ISSUE_W));
    end
  end

  generate
    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
      always_comb begin
        pick_vld[k] = 1'b0;
        pick_cls[k] = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
          if (elig[c] && epos[c] == EW'(k)) begin
            pick_vld[k] = 1'b1;
            pick_cls[k] = CLW'(c);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/age_issue_sel.sv
`timescale 1ns/1ps
module age_issue_sel #(
  parameter int NUM_CLS = 4,
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int TAG_W   = 6,
  parameter int STALL_W = 16,
  localparam int CLW    = $clog2(NUM_CLS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_valid,
  input  logic [SEQ_W-1:0]         ins_seq,
  input  logic [CLW-1:0]           ins_class,
  input  logic [TAG_W-1:0]         ins_tag,
  input  logic [NUM_CLS-1:0]       fu_free,
  input  logic                     squash_valid,
  input  logic [SEQ_W-1:0]         squash_seq,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
  output logic [ISSUE_W*CLW-1:0]   iss_class,
  output logic [ISSUE_W*TAG_W-1:0] iss_tag,
  output logic [NUM_CLS-1:0]       cls_full,
  output logic [STALL_W-1:0]       stall_cnt
);
  localparam int NW = $clog2(NUM_CLS + 1);

  logic [SEQ_W-1:0]   hd_seq  [NUM_CLS];
  logic [TAG_W-1:0]   hd_tag  [NUM_CLS];
  logic [SEQ_W-1:0]   nx_seq  [NUM_CLS];
  logic [NUM_CLS-1:0] nx_ne, ne, pop;
  logic [CLW-1:0]     rank    [NUM_CLS];
  logic [NUM_CLS-1:0] on_list;
  logic [ISSUE_W-1:0] pick_vld;
  logic [CLW-1:0]     pick_cls [ISSUE_W];
  logic [NW-1:0]      n_blocked;

  generate
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
      age_cls_fifo #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_q (
        .clk(clk), .rst(rst),
        .push_en(ins_valid && ins_class == CLW'(g)),
        .push_seq(ins_seq), .push_tag(ins_tag),
        .pop_en(pop[g]),
        .sq_en(squash_valid), .sq_seq(squash_seq),
        .head_seq(hd_seq[g]), .head_tag(hd_tag[g]),
        .nonempty(ne[g]), .full(cls_full[g]),
        .nxt_head_seq(nx_seq[g]), .nxt_nonempty(nx_ne[g])
      );
    end
  endgenerate

  age_rank #(.NUM_CLS(NUM_CLS), .SEQ_W(SEQ_W)) u_rank (
    .clk(clk), .rst(rst), .nxt_head(nx_seq), .nxt_ne(nx_ne),
    .rank(rank), .on_list(on_list)
  );

  age_pick #(.NUM_CLS(NUM_CLS), .ISSUE_W(ISSUE_W)) u_pick (
    .rank(rank), .on_list(on_list), .fu_free(fu_free), .sq_en(squash_valid),
    .pick_vld(pick_vld), .pick_cls(pick_cls), .pop(pop)
  );

  always_comb begin
    n_blocked = '0;
    for (int c = 0; c < NUM_CLS; c++)
      if (ne[c] && !fu_free[c]) n_blocked = n_blocked + NW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= '0;
      iss_seq   <= '0;
      iss_class <= '0;
      iss_tag   <= '0;
      stall_cnt <= '0;
    end else begin
      for (int k = 0; k < ISSUE_W; k++) begin
        iss_valid[k]                <= pick_vld[k];
        iss_seq[k*SEQ_W +: SEQ_W]   <= hd_seq[pick_cls[k]];
        iss_class[k*CLW +: CLW]     <= pick_cls[k];
        iss_tag[k*TAG_W +: TAG_W]   <= hd_tag[pick_cls[k]];
      end
      if (!squash_valid) stall_cnt <= stall_cnt + STALL_W'(n_blocked);
    end
  end
endmodule

// File: rtl/age_issue_chk.sv
`timescale 1ns/1ps
module age_issue_chk #(
  parameter int NUM_CLS = 4,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int STALL_W = 16,
  localparam int CLW    = $clog2(NUM_CLS)
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CLS-1:0]       fu_free,
  input logic                     squash_valid,
  input logic [ISSUE_W-1:0]       iss_valid,
  input logic [ISSUE_W*SEQ_W-1:0] iss_seq,
  input logic [ISSUE_W*CLW-1:0]   iss_class,
  input logic [STALL_W-1:0]       stall_cnt
);
  import age_issue_pkg::*;
  logic [NUM_CLS-1:0] fu_prev;
  always_ff @(posedge clk) fu_prev <= rst ? '0 : fu_free;

  p_slots_packed_r4: assert property (@(posedge clk) disable iff (rst)
    !iss_valid[0] |-> iss_valid == '0);

  p_unit_free_r6: assert property (@(posedge clk) disable iff (rst)
    iss_valid[0] |-> fu_prev[iss_class[CLW-1:0]]);

  p_squash_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> iss_valid == '0);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> $stable(stall_cnt));

  generate
    if (ISSUE_W > 1) begin : g_pair
      p_oldest_first_r4: assert property (@(posedge clk) disable iff (rst)
        iss_valid[1] |-> is_younger(32'(iss_seq[SEQ_W +: SEQ_W]),
                                    32'(iss_seq[SEQ_W-1:0]), SEQ_W));
      p_one_per_class_r4: assert property (@(posedge clk) disable iff (rst)
        iss_valid[1] |-> iss_class[CLW +: CLW] != iss_class[CLW-1:0]);
    end
  endgenerate
endmodule

bind age_issue_sel age_issue_chk #(
  .NUM_CLS(NUM_CLS), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .STALL_W(STALL_W)
) u_chk (
  .clk(clk), .rst(rst), .fu_free(fu_free), .squash_valid(squash_valid),
  .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_class(iss_class),
  .stall_cnt(stall_cnt)
);

// File: tb/sim_age_issue_sel.sv
`timescale 1ns/1ps
module sim_age_issue_sel;
  localparam int NC = 4, DP = 8, W = 2, SW = 8, TW = 6, STW = 16, CLW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0;
  logic [SW-1:0] ins_seq = '0;
  logic [CLW-1:0] ins_class = '0;
  logic [TW-1:0] ins_tag = '0;
  logic [NC-1:0] fu_free = '0;
  logic squash_valid = 1'b0;
  logic [SW-1:0] squash_seq = '0;
  logic [W-1:0] iss_valid;
  logic [W*SW-1:0] iss_seq;
  logic [W*CLW-1:0] iss_class;
  logic [W*TW-1:0] iss_tag;
  logic [NC-1:0] cls_full;
  logic [STW-1:0] stall_cnt;

  always #4 clk = ~clk;

  age_issue_sel #(.NUM_CLS(NC), .DEPTH(DP), .ISSUE_W(W), .SEQ_W(SW), .TAG_W(TW),
                  .STALL_W(STW)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  int mq_seq [NC][$];
  int mq_tag [NC][$];
  int ev [W], es [W], ec [W], et [W];
  int e_stall = 0;
  int nseq = 250;

  function automatic bit younger(int a, int b);
    int d;
    d = (a - b) & 255;
    return d != 0 && d < 128;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, check after the edge
  task automatic step(bit iv, int ic, bit [NC-1:0] fu, bit sq, int sqs, string lbl);
    bit used [NC];
    bit full_pre [NC];
    int s, best, nb;
    s = nseq & 255;
    ins_valid = iv; ins_class = CLW'(ic); ins_seq = SW'(s);
    ins_tag = TW'((s * 5 + ic) & 63);
    fu_free = fu; squash_valid = sq; squash_seq = SW'(sqs);
    for (int k = 0; k < W; k++) ev[k] = 0;
    for (int c = 0; c < NC; c++) begin used[c] = 0; full_pre[c] = mq_seq[c].size() == DP; end
    if (sq) begin
      for (int c = 0; c < NC; c++)
        while (mq_seq[c].size() > 0 && younger(mq_seq[c][$], sqs)) begin
          void'(mq_seq[c].pop_back()); void'(mq_tag[c].pop_back());
        end
      nseq = (sqs + 1) & 255;
    end else begin
      for (int k = 0; k < W; k++) begin
        best = -1;
        for (int c = 0; c < NC; c++)
          if (!used[c] && mq_seq[c].size() > 0 && fu[c])
            if (best < 0 || younger(mq_seq[best][0], mq_seq[c][0])) best = c;
        if (best >= 0) begin
          ev[k] = 1; es[k] = mq_seq[best][0]; ec[k] = best; et[k] = mq_tag[best][0];
          used[best] = 1;
        end
      end
      nb = 0;
      for (int c = 0; c < NC; c++) if (mq_seq[c].size() > 0 && !fu[c]) nb++;
      e_stall = (e_stall + nb) & 16'hffff;
      for (int c = 0; c < NC; c++)
        if (used[c]) begin void'(mq_seq[c].pop_front()); void'(mq_tag[c].pop_front()); end
      if (iv) begin
        if (!full_pre[ic]) begin mq_seq[ic].push_back(s); mq_tag[ic].push_back((s * 5 + ic) & 63); end
        nseq = (nseq + 1 + ($urandom % 2)) & 255;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < W; k++) begin
      chk(iss_valid[k] == ev[k][0], {lbl, " R10 valid"}, int'(iss_valid[k]), ev[k]);
      if (ev[k] != 0 && iss_valid[k]) begin
        chk(int'(iss_seq[k*SW +: SW]) == es[k], {lbl, " R5 seq"}, int'(iss_seq[k*SW +: SW]), es[k]);
        chk(int'(iss_class[k*CLW +: CLW]) == ec[k], {lbl, " R4 class"}, int'(iss_class[k*CLW +: CLW]), ec[k]);
        chk(int'(iss_tag[k*TW +: TW]) == et[k], {lbl, " R2 tag"}, int'(iss_tag[k*TW +: TW]), et[k]);
      end
    end
    for (int c = 0; c < NC; c++)
      chk(cls_full[c] == (mq_seq[c].size() == DP), {lbl, " R3 full"}, int'(cls_full[c]),
          int'(mq_seq[c].size() == DP));
    chk(int'(stall_cnt) == e_stall, {lbl, " R7 stall"}, int'(stall_cnt), e_stall);
  endtask

  task automatic idle(int n, bit [NC-1:0] fu, string lbl);
    for (int i = 0; i < n; i++) step(0, 0, fu, 0, 0, lbl);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(iss_valid == '0, "R1 reset valid", int'(iss_valid), 0);
    chk(stall_cnt == '0, "R1 reset stall", int'(stall_cnt), 0);
    chk(cls_full == '0, "R1 reset full", int'(cls_full), 0);

    // wrap of sequence numbers across 255 -> 0 with all units busy, then drain
    for (int i = 0; i < 8; i++) step(1, (i * 3) % NC, 4'b0000, 0, 0, "R9 wrap");
    idle(8, 4'b1111, "R9 wrap");

    // overfill one class; the ninth insert is dropped
    for (int i = 0; i < DP + 2; i++) step(1, 2, 4'b0000, 0, 0, "R3 overflow");
    idle(8, 4'b1111, "R3 overflow");

    // old entries in a busy class, younger ones elsewhere issue first
    for (int i = 0; i < 4; i++) step(1, 0, 4'b0000, 0, 0, "R6 busy");
    for (int i = 0; i < 4; i++) step(1, 1 + (i % 2), 4'b0000, 0, 0, "R6 busy");
    idle(4, 4'b0110, "R6 busy");
    idle(6, 4'b1111, "R6 busy");

    // squash in the middle of a filled window
    for (int i = 0; i < 10; i++) step(1, i % NC, 4'b0000, 0, 0, "R8 squash");
    step(1, 1, 4'b1111, 1, (nseq - 7) & 255, "R8 squash");
    idle(8, 4'b1111, "R8 squash");

    // long mixed traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0)
        step(1, $urandom % NC, 4'($urandom), 1, (nseq - 1 - ($urandom % 12)) & 255, "R8 random");
      else
        step(($urandom % 4) != 0, $urandom % NC,
             {($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0},
             0, 0, "R4 random");
    end
    idle(12, 4'b1111, "R4 drain");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule